// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Doorbells

This block is a synchronous, true dual-port byte memory of 2048 locations. A left port and a right port each have an active-low select, an active-low output enable, an active-low write strobe, an 11-bit address, write data, registered read data and an active-low write-hold input. Either port may read or write any location in any cycle, independently of the other port.

The two highest addresses also serve as doorbells between the ports. A write by one port to the doorbell of the other port drops that port's active-low interrupt line. The receiving port releases its line by accessing its own doorbell with select and output enable low. Each interrupt line is driven by a small two-state machine per port: `FLAG_CLEAR`, where the line is high, and `FLAG_RAISED`, where the line is low. The transition `FLAG_CLEAR -> FLAG_RAISED` is taken on a *ring* event, which is a peer write to the doorbell. The transition `FLAG_RAISED -> FLAG_CLEAR` is taken on an *acknowledge* event, which is an own doorbell access, and only when no ring occurs in the same cycle. In every other case the state is held. The doorbell bytes are ordinary memory, so a message can travel with the ring.

Top module: `mbox_dpram`

## Requirements
- R1: Every one of the 2048 locations can be written from either port and read back from either port.
- R2: A port writes when select and write strobe are both low and hold is high. A port reads when select and output enable are low and the write strobe is high. Read data appears on `*_rdata` on the clock edge after the read cycle. In any cycle that is not a read, `*_rdata` takes the idle value 0x00 on the next edge.
- R3: A right-port write to address 0x7FE (all ones except bit 0) drives `l_irq_n` low from the next edge.
- R4: A left-port cycle with select and output enable low at 0x7FE drives `l_irq_n` high from the next edge, whatever the level of the write strobe.
- R5: A left-port write to 0x7FF (all ones) drives `r_irq_n` low from the next edge. A right-port cycle with select and output enable low at 0x7FF drives it high again.
- R6: The bytes at 0x7FE and 0x7FF hold whatever data was last written to them, the same as any other location.
- R7: While a port's hold input is low, its write stores nothing and does not ring the doorbell.
- R8: While a port's select is high, the port has no effect on the memory or on the flags, and its read data is 0x00.
- R9: During and after reset, both interrupt lines are high and both read data outputs are 0x00.
- R10: When a ring and an acknowledge of the same flag fall in one cycle, the flag ends up low (ring wins).
- R11: A read of a location that the other port writes in the same cycle returns the data held before that write.
- R12: When both ports write the same address in one cycle, the right port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sel_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_hold_n | input | 1 | Left write hold, low blocks writes |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_hold_n | input | 1 | Right write hold, low blocks writes |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench sweeps the whole address range in both directions, so a decoder that aliased or dropped an address bit would return the wrong bytes. Directed cycles then go after the doorbell corners. One case is an acknowledge made with the write strobe low, which a design that demanded a read would leave pending. Another is a ring under hold, which a design that gated only the store would still signal. A third is a ring and an acknowledge in the same cycle, where a design that gave priority to the clear would lose an interrupt. The bench also checks a read that collides with a write from the other port, which must return the old byte and not the new one, and two writes to one address, where the right port's data must be kept.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/mbox_port_dec.sv
// Decodes one port's strobes into write, read, acknowledge and ring events.
module mbox_port_dec #(
    parameter int          AW       = 11,
    parameter logic [AW-1:0] OWN_BOX  = '1,
    parameter logic [AW-1:0] PEER_BOX = '1
) (
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          hold_n,
    input  logic [AW-1:0] addr,
    output logic          do_wr,
    output logic          do_rd,
    output logic          ack_own,
    output logic          ring_peer
);
    always_comb begin
        do_wr     = !sel_n && !we_n && hold_n;
        do_rd     = !sel_n && !oe_n && we_n;
        ack_own   = !sel_n && !oe_n && (addr == OWN_BOX);
        ring_peer = do_wr && (addr == PEER_BOX);
    end
endmodule

// File: rtl/mbox_mem_core.sv
// Two-port array with registered reads; reads see pre-write contents.
module mbox_mem_core #(
    parameter int            AW        = 11,
    parameter int            DW        = 8,
    parameter logic [DW-1:0] IDLE_DATA = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Port b is applied last, so it wins a same-address collision.
    always_ff @(posedge clk) begin
        if (a_wr) cells[a_addr] <= a_wdata;
        if (b_wr) cells[b_addr] <= b_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdata <= IDLE_DATA;
            b_rdata <= IDLE_DATA;
        end else begin
            a_rdata <= a_rd ? cells[a_addr] : IDLE_DATA;
            b_rdata <= b_rd ? cells[b_addr] : IDLE_DATA;
        end
    end
endmodule

// File: rtl/mbox_flag.sv
// Doorbell flag: ring raises it, acknowledge clears it, ring wins a tie.
module mbox_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic ack,
    output logic irq_n
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (ring)         state_d = FLAG_RAISED;
            FLAG_RAISED: if (ack && !ring) state_d = FLAG_CLEAR;
            default:                       state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
    parameter int            AW        = 11,
    parameter int            DW        = 8,
    parameter logic [DW-1:0] IDLE_DATA = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_sel_n,
    input  logic          l_oe_n,
    input  logic          l_we_n,
    input  logic          l_hold_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_irq_n,
    input  logic          r_sel_n,
    input  logic          r_oe_n,
    input  logic          r_we_n,
    input  logic          r_hold_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_irq_n
);
    localparam logic [AW-1:0] BOX_LEFT  = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] BOX_RIGHT = {AW{1'b1}};

    logic l_wr, l_rd, l_ack, l_ring;
    logic r_wr, r_rd, r_ack, r_ring;

    mbox_port_dec #(.AW(AW), .OWN_BOX(BOX_LEFT), .PEER_BOX(BOX_RIGHT)) u_dec_l (
        .sel_n(l_sel_n), .oe_n(l_oe_n), .we_n(l_we_n), .hold_n(l_hold_n),
        .addr(l_addr), .do_wr(l_wr), .do_rd(l_rd), .ack_own(l_ack), .ring_peer(l_ring)
    );

    mbox_port_dec #(.AW(AW), .OWN_BOX(BOX_RIGHT), .PEER_BOX(BOX_LEFT)) u_dec_r (
        .sel_n(r_sel_n), .oe_n(r_oe_n), .we_n(r_we_n), .hold_n(r_hold_n),
        .addr(r_addr), .do_wr(r_wr), .do_rd(r_rd), .ack_own(r_ack), .ring_peer(r_ring)
    );

    mbox_mem_core #(.AW(AW), .DW(DW), .IDLE_DATA(IDLE_DATA)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .a_wr(l_wr), .a_rd(l_rd), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
        .b_wr(r_wr), .b_rd(r_rd), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
    );

    mbox_flag u_flag_l (
        .clk(clk), .rst_n(rst_n), .ring(r_ring), .ack(l_ack), .irq_n(l_irq_n)
    );

    mbox_flag u_flag_r (
        .clk(clk), .rst_n(rst_n), .ring(l_ring), .ack(r_ack), .irq_n(r_irq_n)
    );
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
    parameter int            AW        = 11,
    parameter int            DW        = 8,
    parameter logic [DW-1:0] IDLE_DATA = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_sel_n,
    input logic          l_oe_n,
    input logic          l_we_n,
    input logic          l_hold_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_rdata,
    input logic          l_irq_n,
    input logic          r_sel_n,
    input logic          r_oe_n,
    input logic          r_we_n,
    input logic          r_hold_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_irq_n
);
    localparam logic [AW-1:0] BOX_LEFT  = {{(AW-1){1'b1}}, 1'b0};
    localparam logic [AW-1:0] BOX_RIGHT = {AW{1'b1}};

    logic ring_left, ring_right, ack_left, ack_right;
    always_comb begin
        ring_left  = !r_sel_n && !r_we_n && r_hold_n && (r_addr == BOX_LEFT);
        ring_right = !l_sel_n && !l_we_n && l_hold_n && (l_addr == BOX_RIGHT);
        ack_left   = !l_sel_n && !l_oe_n && (l_addr == BOX_LEFT);
        ack_right  = !r_sel_n && !r_oe_n && (r_addr == BOX_RIGHT);
    end

    AST_LEFT_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ring_left |=> !l_irq_n); // R3
    AST_LEFT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_left && !ring_left) |=> l_irq_n); // R4
    AST_RIGHT_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ring_right |=> !r_irq_n); // R5
    AST_RIGHT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_right && !ring_right) |=> r_irq_n); // R5
    AST_HOLD_NO_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !ring_left) |=> l_irq_n); // R7
    AST_LEFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        l_sel_n |=> (l_rdata == IDLE_DATA)); // R8
    AST_RIGHT_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!r_sel_n && !r_oe_n && r_we_n) |=> (r_rdata == IDLE_DATA)); // R2
    AST_RING_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_left && ack_left) |=> !l_irq_n); // R10
endmodule

bind mbox_dpram mbox_dpram_chk #(.AW(AW), .DW(DW), .IDLE_DATA(IDLE_DATA)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_hold_n(l_hold_n),
    .l_addr(l_addr), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_hold_n(r_hold_n),
    .r_addr(r_addr), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
);

// File: tb/mbox_dpram_bench.sv
`timescale 1ns/1ps
module mbox_dpram_bench;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] BOX_L = 11'h7FE;
    localparam logic [AW-1:0] BOX_R = 11'h7FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_sel_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1, l_hold_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          l_irq_n;
    logic          r_sel_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1, r_hold_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;
    logic          r_irq_n;

    always #10 clk = ~clk;

    mbox_dpram u_mbox_dpram (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_hold_n(l_hold_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_hold_n(r_hold_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] exp_lr = '0, exp_rr = '0;
    logic          exp_li = 1'b1, exp_ri = 1'b1;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle on both ports (called at a falling edge), predict, and
    // return at the next falling edge when the registered outputs are settled.
    task automatic step(input logic ls, input logic lo, input logic lw, input logic lh,
                        input logic [AW-1:0] la, input logic [DW-1:0] ld,
                        input logic rs, input logic ro, input logic rw, input logic rh,
                        input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        logic wl, wr, set_l, set_r, clr_l, clr_r;
        l_sel_n = ls; l_oe_n = lo; l_we_n = lw; l_hold_n = lh; l_addr = la; l_wdata = ld;
        r_sel_n = rs; r_oe_n = ro; r_we_n = rw; r_hold_n = rh; r_addr = ra; r_wdata = rd;
        exp_lr = (!ls && !lo && lw) ? mdl[la] : 8'h00;
        exp_rr = (!rs && !ro && rw) ? mdl[ra] : 8'h00;
        wl = !ls && !lw && lh;
        wr = !rs && !rw && rh;
        set_l = wr && (ra == BOX_L);
        set_r = wl && (la == BOX_R);
        clr_l = !ls && !lo && (la == BOX_L);
        clr_r = !rs && !ro && (ra == BOX_R);
        if (wl) mdl[la] = ld;
        if (wr) mdl[ra] = rd;
        exp_li = set_l ? 1'b0 : (clr_l ? 1'b1 : exp_li);
        exp_ri = set_r ? 1'b0 : (clr_r ? 1'b1 : exp_ri);
        @(negedge clk);
    endtask

    localparam logic X = 1'b1;  // idle level for a strobe

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 l_rdata in reset", l_rdata, 8'h00);
        chk("R9 l_irq_n in reset", {7'd0, l_irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 r_rdata after reset", r_rdata, 8'h00);
        chk("R9 r_irq_n after reset", {7'd0, r_irq_n}, 8'h01);

        // R1: left writes every address, right reads every address
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] v;
            v = 8'(a * 7 + 3) ^ 8'(a >> 8);
            step(0, X, 0, 1, AW'(a), v, X, X, X, 1, '0, '0);
            if (a % 256 == 5) chk("R2 idle during write", l_rdata, exp_lr);
        end
        chk("R5 left ring via sweep", {7'd0, r_irq_n}, {7'd0, exp_ri});
        for (int a = 0; a < DEPTH; a++) begin
            step(X, X, X, 1, '0, '0, 0, 0, 1, 1, AW'(a), '0);
            chk("R1 right reads left data", r_rdata, exp_rr);
        end
        chk("R5 right ack via sweep", {7'd0, r_irq_n}, 8'h01);

        // R1: right writes every address, left reads every address
        for (int a = 0; a < DEPTH; a++) begin
            step(X, X, X, 1, '0, '0, 0, X, 0, 1, AW'(a), 8'(a * 13 + 91));
        end
        chk("R3 right ring via sweep", {7'd0, l_irq_n}, 8'h00);
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, 1, 1, AW'(a), '0, X, X, X, 1, '0, '0);
            chk("R1 left reads right data", l_rdata, exp_lr);
        end
        chk("R4 left ack via sweep", {7'd0, l_irq_n}, 8'h01);

        // R3 / R6: right rings the left doorbell with a message
        step(X, X, X, 1, '0, '0, 0, X, 0, 1, BOX_L, 8'hA5);
        chk("R3 l_irq_n low", {7'd0, l_irq_n}, 8'h00);
        // R4: acknowledge with write strobe low (also a write of 0x3C)
        step(0, 0, 0, 1, BOX_L, 8'h3C, X, X, X, 1, '0, '0);
        chk("R4 ack with write strobe low", {7'd0, l_irq_n}, 8'h01);
        step(X, X, X, 1, '0, '0, 0, 0, 1, 1, BOX_L, '0);
        chk("R6 doorbell byte stored", r_rdata, 8'h3C);

        // R5 / R6: left rings the right doorbell, right reads message and acks
        step(0, X, 0, 1, BOX_R, 8'h5A, X, X, X, 1, '0, '0);
        chk("R5 r_irq_n low", {7'd0, r_irq_n}, 8'h00);
        step(X, X, X, 1, '0, '0, 0, 0, 1, 1, BOX_R, '0);
        chk("R6 right reads message", r_rdata, 8'h5A);
        chk("R5 r_irq_n released", {7'd0, r_irq_n}, 8'h01);

        // R7: held right write to the left doorbell and to plain memory
        step(X, X, X, 1, '0, '0, 0, X, 0, 0, BOX_L, 8'hEE);
        chk("R7 held write no ring", {7'd0, l_irq_n}, 8'h01);
        step(X, X, X, 1, '0, '0, 0, X, 0, 0, 11'h123, 8'hEE);
        step(0, 0, 1, 1, BOX_L, '0, X, X, X, 1, '0, '0);
        chk("R7 held write no store (box)", l_rdata, 8'h3C);
        step(0, 0, 1, 1, 11'h123, '0, X, X, X, 1, '0, '0);
        chk("R7 held write no store", l_rdata, exp_lr);

        // R8: deselected port with strobes low has no effect
        step(1, 0, 0, 1, BOX_R, 8'h77, 1, 0, 0, 1, BOX_L, 8'h77);
        chk("R8 idle l_rdata", l_rdata, 8'h00);
        chk("R8 no ring on right", {7'd0, r_irq_n}, 8'h01);
        chk("R8 no ring on left", {7'd0, l_irq_n}, 8'h01);
        step(0, 0, 1, 1, BOX_R, '0, X, X, X, 1, '0, '0);
        chk("R8 no store when deselected", l_rdata, 8'h5A);

        // R10: ring and acknowledge of the left flag in the same cycle
        step(0, 0, 1, 1, BOX_L, '0, 0, X, 0, 1, BOX_L, 8'h11);
        chk("R10 ring wins over ack", {7'd0, l_irq_n}, 8'h00);
        step(0, 0, 1, 1, BOX_L, '0, X, X, X, 1, '0, '0);
        chk("R4 later ack clears", {7'd0, l_irq_n}, 8'h01);
        chk("R6 box read after tie", l_rdata, 8'h11);

        // R11: right reads a location the left writes in the same cycle
        step(0, X, 0, 1, 11'h040, 8'hC3, 0, 0, 1, 1, 11'h040, '0);
        chk("R11 old data on collision", r_rdata, exp_rr);
        step(X, X, X, 1, '0, '0, 0, 0, 1, 1, 11'h040, '0);
        chk("R11 new data after", r_rdata, 8'hC3);

        // R12: both ports write one address
        step(0, X, 0, 1, 11'h2AA, 8'h01, 0, X, 0, 1, 11'h2AA, 8'h02);
        step(0, 0, 1, 1, 11'h2AA, '0, X, X, X, 1, '0, '0);
        chk("R12 right write kept", l_rdata, 8'h02);

        // R2: output enable high on a selected port gives idle data
        step(0, 1, 1, 1, 11'h2AA, '0, X, X, X, 1, '0, '0);
        chk("R2 oe high gives idle", l_rdata, 8'h00);

        summary();
    end
endmodule